// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the command, bank and address lines from reset until the memory is ready for normal traffic. It holds the clock enable low through a long stable-clock wait. It then raises the clock enable under a NOP and walks a fixed order of commands: precharge of all banks, an extended mode load that turns the DLL on, a mode load that resets the DLL and programs the operating fields, a second precharge of all banks, two auto refreshes, and a final mode load without the DLL reset. NOP cycles fill each gap for the precharge time, the mode-load time or the refresh cycle time.

Two flags report progress. `seq_done_o` rises once the gap after the last mode load has run out. `read_ok_o` rises only when the sequence is done and the DLL lock window has also expired. That window is counted from the cycle of the DLL-reset load. Normal read/write scheduling takes over the lines after `seq_done_o`, and it must hold back reads until `read_ok_o`. The operating fields are plain inputs and must stay stable during the sequence. No stream or handshake interface exists; every pin is plain control or status.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, `cke_o` is 0, `cmd_o` is NOP, and `seq_done_o` and `read_ok_o` are 0. The command codes are 0 NOP, 1 PRECHARGE ALL, 2 LOAD MODE and 3 AUTO REFRESH.
- R2: For the first `T_STABLE` cycles after reset release, `cke_o` stays 0 and `cmd_o` stays NOP.
- R3: In cycle `T_STABLE` a NOP is driven with `cke_o` high, and `cke_o` stays high from then on. The next cycle carries PRECHARGE ALL with address bit 10 set, bank 0 and all other address bits 0.
- R4: `T_RP` cycles after the first precharge, a LOAD MODE is driven to bank 1 (bank bits 1:0 = 01) with an all-zero address, which enables the DLL.
- R5: `T_MRD` cycles later, a LOAD MODE is driven to bank 0. Its address carries burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, bit 8 = 1 (DLL reset), and bit 7 and bits 12:9 = 0.
- R6: `T_MRD` cycles after that comes PRECHARGE ALL (address bit 10 set). `T_RP` cycles later comes AUTO REFRESH, and a second AUTO REFRESH follows `T_RFC` cycles after the first. Both refreshes use bank 0 and address 0.
- R7: `T_RFC` cycles after the second refresh, a LOAD MODE to bank 0 carries the same fields in bits 6:0, with bits 12:7 all 0.
- R8: Every cycle between two sequence commands is a NOP with bank and address 0.
- R9: `seq_done_o` rises exactly `T_MRD` cycles after the final mode load. It then stays high, and only NOPs follow.
- R10: `read_ok_o` is high only when `seq_done_o` is high and at least `DLL_LOCK` cycles have passed since the DLL-reset mode load. It rises in the first cycle where both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst-length field for the mode loads |
| burst_type_i | input | 1 | Burst-type field (0 sequential, 1 interleaved) |
| cas_lat_i | input | 3 | CAS-latency field |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 3 | Command code (0 NOP, 1 PRECHARGE ALL, 2 LOAD MODE, 3 AUTO REFRESH) |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| seq_done_o | output | 1 | Sequence finished |
| read_ok_o | output | 1 | Reads may be issued |

## Verification
Two events can land in the same cycle: the end of the final mode-load gap, which raises the done flag, and the expiry of the DLL lock window, which is counted separately. A second instance uses a lock count equal to the exact cycle distance from the DLL-reset load to the end of the sequence, so both events coincide. The read-allowed flag must then rise together with done, neither one cycle early nor one cycle late. The first instance keeps the full 200-cycle window, so its done flag leads and its read flag is judged alone later on.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_LMR  = 3'd2,
    CMD_AREF = 3'd3
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_WAKE,
    ST_PRE1,
    ST_EMR,
    ST_MRR,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_MRN,
    ST_DONE
  } init_step_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_step_timer.sv
module ddr_step_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] len_i,
  output logic          first_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (last_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ddr_dll_window.sv
module ddr_dll_window #(
  parameter int DLL_LOCK = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);

  localparam int DW = $clog2(DLL_LOCK + 1);

  logic [DW-1:0] left_q;
  logic          armed_q;

  assign expired_o = armed_q && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      left_q  <= DW'(DLL_LOCK - 1);
      armed_q <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  init_step_e        step_i,
  input  logic              first_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  output logic              cke_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int AP_BIT  = 10;
  localparam int DLLR_BIT = 8;

  logic [6:0] fields;
  assign fields = {cas_lat_i, burst_type_i, burst_len_i};

  always_comb begin
    cke_o  = (step_i != ST_WAIT);
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (first_i) begin
      unique case (step_i)
        ST_PRE1, ST_PRE2: begin
          cmd_o          = CMD_PREA;
          addr_o[AP_BIT] = 1'b1;
        end
        ST_EMR: begin
          cmd_o = CMD_LMR;
          ba_o  = BA_W'(1);
        end
        ST_MRR: begin
          cmd_o            = CMD_LMR;
          addr_o[6:0]      = fields;
          addr_o[DLLR_BIT] = 1'b1;
        end
        ST_MRN: begin
          cmd_o       = CMD_LMR;
          addr_o[6:0] = fields;
        end
        ST_REF1, ST_REF2: cmd_o = CMD_AREF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int T_STABLE = 20000,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 10,
  parameter int DLL_LOCK = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  output logic              cke_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              seq_done_o,
  output logic              read_ok_o
);

  localparam int GAP_MAX = imax(imax(T_STABLE, T_RP), imax(T_MRD, T_RFC));
  localparam int CW      = $clog2(GAP_MAX + 1);

  init_step_e    step_q;
  logic [CW-1:0] len;
  logic          first, last, dll_ok;

  always_comb begin
    unique case (step_q)
      ST_WAIT:                len = CW'(T_STABLE);
      ST_PRE1, ST_PRE2:       len = CW'(T_RP);
      ST_EMR, ST_MRR, ST_MRN: len = CW'(T_MRD);
      ST_REF1, ST_REF2:       len = CW'(T_RFC);
      default:                len = CW'(1);
    endcase
  end

  ddr_step_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .len_i   (len),
    .first_o (first),
    .last_o  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_WAIT;
    end else if (last && step_q != ST_DONE) begin
      step_q <= init_step_e'(step_q + 4'd1);
    end
  end

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .step_i       (step_q),
    .first_i      (first),
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .cke_o        (cke_o),
    .cmd_o        (cmd_o),
    .ba_o         (ba_o),
    .addr_o       (addr_o)
  );

  ddr_dll_window #(.DLL_LOCK(DLL_LOCK)) u_dll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (step_q == ST_MRR && first),
    .expired_o (dll_ok)
  );

  assign seq_done_o = (step_q == ST_DONE);
  assign read_ok_o  = seq_done_o && dll_ok;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int DLL_LOCK = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_o,
  input logic [2:0]        cmd_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              seq_done_o,
  input logic              read_ok_o
);

  localparam int CW = $clog2(DLL_LOCK + 2);

  logic [CW-1:0] since_q;
  logic          seen_q;
  logic          dll_rst_load;

  assign dll_rst_load = (cmd_o == 3'd2) && (ba_o == '0) && addr_o[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (dll_rst_load) begin
      since_q <= CW'(1);
      seen_q  <= 1'b1;
    end else if (seen_q && since_q < CW'(DLL_LOCK)) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_cmd_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd3);

  p_nop_while_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> cmd_o == 3'd0);

  p_cke_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  p_mode_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd2 && ba_o == '0) |-> (addr_o[12:9] == 4'd0 && !addr_o[7]));

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |=> seq_done_o);

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> cmd_o == 3'd0);

  p_read_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok_o |-> seq_done_o);

  p_read_after_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok_o |-> (seen_q && since_q >= CW'(DLL_LOCK)));

endmodule

bind ddr_init_seq ddr_init_chk #(
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .DLL_LOCK (DLL_LOCK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke_o      (cke_o),
  .cmd_o      (cmd_o),
  .ba_o       (ba_o),
  .addr_o     (addr_o),
  .seq_done_o (seq_done_o),
  .read_ok_o  (read_ok_o)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

  localparam int TS = 50, TRP = 3, TMRD = 2, TRFC = 8;
  localparam int DLL0 = 200;
  localparam int DLL1 = TMRD + TRP + 2 * TRFC + TMRD; // coincides with done

  typedef struct packed {
    logic        cke;
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        done;
    logic        rdok;
  } obs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] bl0 = 3'b011, cl0 = 3'b110, bl1 = 3'b010, cl1 = 3'b010;
  logic       bt0 = 1'b1, bt1 = 1'b0;

  obs_t o0, o1;
  int checks = 0, fails = 0;
  bit finished = 0;

  ddr_init_seq #(.T_STABLE(TS), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .DLL_LOCK(DLL0)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_len_i(bl0), .burst_type_i(bt0), .cas_lat_i(cl0),
    .cke_o(o0.cke), .cmd_o(o0.cmd), .ba_o(o0.ba), .addr_o(o0.addr),
    .seq_done_o(o0.done), .read_ok_o(o0.rdok));

  ddr_init_seq #(.T_STABLE(TS), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .DLL_LOCK(DLL1)) u1 (
    .clk(clk), .rst_n(rst_n), .burst_len_i(bl1), .burst_type_i(bt1), .cas_lat_i(cl1),
    .cke_o(o1.cke), .cmd_o(o1.cmd), .ba_o(o1.ba), .addr_o(o1.addr),
    .seq_done_o(o1.done), .read_ok_o(o1.rdok));

  // Behavioural reference: expected pins k cycles after reset release.
  function automatic obs_t expect_at(int k, int dll, logic [2:0] bl, logic bt, logic [2:0] cl);
    obs_t e;
    int t1, t2, t3, t4, t5, t6, t7, t8;
    e = '0;
    t1 = TS + 1; t2 = t1 + TRP; t3 = t2 + TMRD; t4 = t3 + TMRD;
    t5 = t4 + TRP; t6 = t5 + TRFC; t7 = t6 + TRFC; t8 = t7 + TMRD;
    e.cke = (k >= TS);
    if (k == t1 || k == t4) begin e.cmd = 3'd1; e.addr[10] = 1'b1; end
    if (k == t2) begin e.cmd = 3'd2; e.ba = 2'b01; end
    if (k == t3) begin e.cmd = 3'd2; e.addr = {4'b0, 1'b1, 1'b0, cl, bt, bl}; end
    if (k == t5 || k == t6) e.cmd = 3'd3;
    if (k == t7) begin e.cmd = 3'd2; e.addr = {6'b0, cl, bt, bl}; end
    e.done = (k >= t8);
    e.rdok = (k >= t8) && (k >= t3 + dll);
    return e;
  endfunction

  function automatic string req_of(int k, int dll);
    int t1, t3, t4, t5, t7, t8;
    t1 = TS + 1; t3 = t1 + TRP + TMRD; t4 = t3 + TMRD;
    t5 = t4 + TRP; t7 = t5 + 2 * TRFC; t8 = t7 + TMRD;
    if (k < TS) return "R2";
    if (k <= t1) return "R3";
    if (k < t3) return "R4";
    if (k < t4) return "R5";
    if (k < t7) return "R6";
    if (k < t8) return "R7";
    if (k >= t3 + dll || k == t8) return "R10";
    return "R9";
  endfunction

  task automatic check(string tag, string req, obs_t act, obs_t exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s: cke=%b cmd=%0d ba=%b addr=%h done=%b rdok=%b expected cke=%b cmd=%0d ba=%b addr=%h done=%b rdok=%b",
               tag, req, act.cke, act.cmd, act.ba, act.addr, act.done, act.rdok,
               exp_v.cke, exp_v.cmd, exp_v.ba, exp_v.addr, exp_v.done, exp_v.rdok);
    end
  endtask

  initial begin
    obs_t idle;
    idle = '0;
    repeat (3) @(negedge clk);
    // R1: reset state on both instances
    check("u0", "R1", o0, idle);
    check("u1", "R1", o1, idle);
    rst_n = 1'b1;
    // R2..R10: compare every cycle; R8 NOP gaps covered by the same compare
    for (int k = 1; k <= 320; k++) begin
      @(negedge clk);
      check("u0", req_of(k, DLL0), o0, expect_at(k, DLL0, bl0, bt0, cl0));
      check("u1", req_of(k, DLL1), o1, expect_at(k, DLL1, bl1, bt1, cl1));
    end
    // R10 coincidence: u1 read flag rose with done; u0 read flag late but up
    check("u1", "R10", o1, expect_at(400, DLL1, bl1, bt1, cl1));
    check("u0", "R10", o0, expect_at(400, DLL0, bl0, bt0, cl0));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule